// File: doc/BRIEF.md
# NAND Identification Responder

This block is the device side of a NAND target that only answers identification traffic. It watches the host's latch strobes, sampled on the system clock. A rising write strobe with chip-enable low captures a command byte when the command-latch input is high, or an address byte when the address-latch input is high. The block recognises the read-ID command (90h) and the parameter-page command (ECh). Each of them takes effect once the address byte 00h follows it. The block also takes a reset command (FFh). Any other byte returns it to idle.

In a data mode, every falling edge of the read strobe while chip-enable is low puts the next byte from an internal pointer on the output bus. The pointer then moves on by one. The parameter page image is 256 bytes of constant content. Its last two bytes hold a 16-bit check value. A small engine computes that value once after reset, and the ready/busy output stays low until the engine has finished. Reads walk through the image, then through repeated copies of it, and past the last copy they return FFh. A mode stays in force until the next command is latched.

Top module: `nand_id_responder`

## Requirements
- R1: After rst_n releases, rb_n is low for exactly 254 clock cycles while the check value is computed, then goes high; io_oe is low throughout.
- R2: Command 90h followed by address 00h enters ID mode. The reads then return 01h, A5h, D2h, 15h and 5Eh in that order, and every later read returns 00h.
- R3: A data mode persists until a new command is latched. An address cycle the decoder is not waiting for has no effect on the mode or on the pointer, and neither has a period with ce_n high.
- R4: io_oe is high only while ce_n is low and re_n is low in a data mode. A read-strobe fall with ce_n high does not advance the pointer.
- R5: Command ECh followed by address 00h enters parameter mode, whose bytes 0 to 3 read 4Fh, 4Eh, 46h, 49h.
- R6: Byte 254 holds the low byte and byte 255 the high byte of a CRC over bytes 0 to 253. The CRC uses polynomial 8005h and processes each byte MSB first, starting from 4F4Eh, with no final inversion.
- R7: With COPIES=3, bytes 256 to 511 and 512 to 767 equal bytes 0 to 255, and every read at byte 768 or later returns FFh.
- R8: An address byte other than 00h after 90h or ECh returns the block to idle, so later reads leave io_oe low.
- R9: A command byte other than 90h, ECh or FFh returns the block to idle with output disabled. rb_n stays high.
- R10: Command FFh sets the block to idle and holds rb_n low for exactly BUSY_CYCLES clock cycles.
- R11: While rb_n is low, every command and address cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| we_n | input | 1 | Write strobe; the rising edge latches io_in |
| re_n | input | 1 | Read strobe; the falling edge sources the next byte |
| io_in | input | 8 | Command or address byte from the host |
| io_out | output | 8 | Byte sourced to the host |
| io_oe | output | 1 | Output enable for io_out |
| rb_n | output | 1 | Ready (1) or busy (0) |

## Verification
The bench builds the block with BUSY_CYCLES=12. That makes the reset-command busy window long enough for a full command and address sequence to land inside it, which exercises the rule that such cycles are ignored. COPIES keeps its default of 3, and the bench reads 800 bytes of the parameter page. That sweep crosses both copy boundaries, reaches the saturating FFh fill, and recomputes the CRC from the bytes as they are read. The power-up busy length of 254 cycles and the exact busy length after a reset command are both counted cycle by cycle.

// File: rtl/nidr_pkg.sv
// Package: shared mode type and fixed identification constants.
// Assumes byte-wide bus and a 256-byte parameter image.
package nidr_pkg;

    typedef enum logic [2:0] {
        M_IDLE   = 3'd0,
        M_ID_ADR = 3'd1,
        M_ID     = 3'd2,
        M_PP_ADR = 3'd3,
        M_PP     = 3'd4
    } nidr_mode_e;

    localparam int          PAGE_BYTES = 256;
    localparam int          CRC_LEN    = PAGE_BYTES - 2;
    localparam int          ID_LEN     = 5;
    localparam logic [7:0]  CMD_ID     = 8'h90;
    localparam logic [7:0]  CMD_PP     = 8'hEC;
    localparam logic [7:0]  CMD_RST    = 8'hFF;
    localparam logic [7:0]  ADR_ZERO   = 8'h00;
    localparam logic [15:0] CRC_POLY   = 16'h8005;

    // Element 0 is sourced first.
    localparam logic [ID_LEN-1:0][7:0] ID_BYTES =
        {8'h5E, 8'h15, 8'hD2, 8'hA5, 8'h01};

endpackage

// File: rtl/nidr_edge.sv
// Module: edge detector for W active-low strobes sampled on clk.
// Assumes strobes are already synchronous to clk; idle level is 1.
module nidr_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] strb_n,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    // Remember last sampled level of every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= strb_n;
    end

    for (genvar g = 0; g < W; g++) begin : g_edge
        assign rise[g] = ~prev_q[g] &  strb_n[g];
        assign fall[g] =  prev_q[g] & ~strb_n[g];
    end
endmodule

// File: rtl/nidr_cmd.sv
// Module: command/address decoder and reset-busy timer.
// Assumes 'latch' pulses for one cycle per write-strobe rising edge with
// chip enable low; 'hold' blocks decoding while the page engine runs.
module nidr_cmd
    import nidr_pkg::*;
#(
    parameter int BUSY_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       latch,
    input  logic       cle,
    input  logic       ale,
    input  logic [7:0] io_in,
    input  logic       hold,
    output nidr_mode_e mode,
    output logic       busy
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);
    localparam logic [BW-1:0] BUSY_LOAD = BW'(BUSY_CYCLES);

    logic [BW-1:0] cnt_q;
    logic          take;

    assign take = latch & ~hold & ~busy;
    assign busy = (cnt_q != '0);

    // Mode register: commands set the mode, expected address confirms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= M_IDLE;
        end else if (take && cle && !ale) begin
            case (io_in)
                CMD_ID:  mode <= M_ID_ADR;
                CMD_PP:  mode <= M_PP_ADR;
                default: mode <= M_IDLE;
            endcase
        end else if (take && ale && !cle) begin
            if (mode == M_ID_ADR)
                mode <= (io_in == ADR_ZERO) ? M_ID : M_IDLE;
            else if (mode == M_PP_ADR)
                mode <= (io_in == ADR_ZERO) ? M_PP : M_IDLE;
        end
    end

    // Busy timer: loaded by the reset command, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (take && cle && !ale && io_in == CMD_RST)
            cnt_q <= BUSY_LOAD;
        else if (busy)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/nidr_ppage.sv
// Module: constant parameter image plus a check-value engine.
// Assumes one image byte per cycle is folded into the CRC after reset;
// bytes 254/255 are served from the computed CRC register.
module nidr_ppage
    import nidr_pkg::*;
#(
    parameter logic [15:0] CRC_INIT = 16'h4F4E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       done
);
    localparam logic [7:0] LAST = 8'(CRC_LEN);

    logic [7:0]  idx_q;
    logic [15:0] crc_q;

    function automatic logic [7:0] img(input logic [7:0] a);
        case (a) inside
            8'd0:   return 8'h4F;
            8'd1:   return 8'h4E;
            8'd2:   return 8'h46;
            8'd3:   return 8'h49;
            8'd4:   return 8'h02;
            8'd6:   return 8'h1E;
            8'd8:   return 8'h3B;
            [8'd32:8'd63]: return 8'h20;
            8'd64:  return 8'h01;
            8'd81:  return 8'h08;
            8'd84:  return 8'h80;
            8'd92:  return 8'h40;
            8'd97:  return 8'h40;
            8'd100: return 8'h01;
            8'd101: return 8'h23;
            8'd102: return 8'h01;
            8'd103: return 8'h47;
            8'd104: return 8'h01;
            8'd105: return 8'h01;
            8'd106: return 8'h05;
            8'd107: return 8'h01;
            8'd108: return 8'h01;
            8'd109: return 8'h03;
            8'd110: return 8'h04;
            8'd112: return 8'h04;
            8'd113: return 8'h01;
            8'd114: return 8'h04;
            8'd128: return 8'h0A;
            8'd129: return 8'h03;
            8'd131: return 8'h03;
            8'd133: return 8'hBC;
            8'd134: return 8'h02;
            8'd135: return 8'h10;
            8'd136: return 8'h27;
            8'd137: return 8'h1E;
            8'd139: return 8'hC8;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c,
                                             input logic [7:0]  d);
        logic [15:0] r;
        r = c;
        for (int b = 7; b >= 0; b--) begin
            if (r[15] ^ d[b]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    assign done = (idx_q == LAST);

    // Walk bytes 0..253 once after reset, folding each into the CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            crc_q <= CRC_INIT;
        end else if (!done) begin
            idx_q <= idx_q + 1'b1;
            crc_q <= crc_step(crc_q, img(idx_q));
        end
    end

    // Read port: last two bytes come from the CRC, low byte first.
    always_comb begin
        if (rd_addr == LAST)             rd_data = crc_q[7:0];
        else if (rd_addr == LAST + 8'd1) rd_data = crc_q[15:8];
        else                             rd_data = img(rd_addr);
    end
endmodule

// File: rtl/nidr_rdpath.sv
// Module: byte pointer, output register and output enable.
// Assumes the pointer is cleared whenever no data mode is active.
module nidr_rdpath
    import nidr_pkg::*;
#(
    parameter int COPIES = 3,
    parameter int PTR_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  nidr_mode_e       mode,
    input  logic             ce_n,
    input  logic             re_n,
    input  logic             re_fall,
    input  logic [7:0]       pg_data,
    output logic [PTR_W-1:0] ptr,
    output logic [7:0]       io_out,
    output logic             io_oe
);
    localparam logic [PTR_W-1:0] LIMIT  = PTR_W'(COPIES * PAGE_BYTES);
    localparam logic [PTR_W-1:0] ID_END = PTR_W'(ID_LEN);

    logic       data_mode;
    logic [7:0] id_byte;
    logic [7:0] pp_byte;
    logic [7:0] nxt_byte;

    assign data_mode = (mode == M_ID) || (mode == M_PP);
    assign id_byte   = (ptr < ID_END) ? ID_BYTES[ptr[2:0]] : 8'h00;
    assign pp_byte   = (ptr < LIMIT) ? pg_data : 8'hFF;
    assign nxt_byte  = (mode == M_ID) ? id_byte : pp_byte;

    // Drive enable only while selected, reading, and in a data mode.
    always_ff @(posedge clk) begin
        if (!rst_n) io_oe <= 1'b0;
        else        io_oe <= ~ce_n & ~re_n & data_mode;
    end

    // Source a byte and step the pointer on each selected read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            io_out <= '0;
        end else if (!data_mode) begin
            ptr <= '0;
        end else if (re_fall && !ce_n) begin
            io_out <= nxt_byte;
            if (ptr != LIMIT) ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/nand_id_responder.sv
// Module: top of the identification responder.
// Assumes host strobes are synchronous to clk and held for at least one
// cycle at each level.
module nand_id_responder
    import nidr_pkg::*;
#(
    parameter int          BUSY_CYCLES = 16,
    parameter int          COPIES      = 3,
    parameter logic [15:0] CRC_INIT    = 16'h4F4E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       rb_n
);
    localparam int PTR_W = $clog2(COPIES * PAGE_BYTES + 1);

    logic [1:0]       rise;
    logic [1:0]       fall;
    nidr_mode_e       mode;
    logic             busy;
    logic             crc_done;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       pg_data;

    assign rb_n = crc_done & ~busy;

    nidr_edge #(.W(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strb_n ({re_n, we_n}),
        .rise   (rise),
        .fall   (fall)
    );

    nidr_cmd #(.BUSY_CYCLES(BUSY_CYCLES)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .latch (rise[0] & ~ce_n),
        .cle   (cle),
        .ale   (ale),
        .io_in (io_in),
        .hold  (~crc_done),
        .mode  (mode),
        .busy  (busy)
    );

    nidr_ppage #(.CRC_INIT(CRC_INIT)) u_ppage (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (ptr[7:0]),
        .rd_data (pg_data),
        .done    (crc_done)
    );

    nidr_rdpath #(.COPIES(COPIES), .PTR_W(PTR_W)) u_rdpath (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .ce_n    (ce_n),
        .re_n    (re_n),
        .re_fall (fall[1]),
        .pg_data (pg_data),
        .ptr     (ptr),
        .io_out  (io_out),
        .io_oe   (io_oe)
    );
endmodule

// File: rtl/nidr_chk.sv
// Module: property checker bound into the responder top.
// Assumes the same strobe sampling convention as the design.
module nidr_chk
    import nidr_pkg::*;
#(
    parameter int COPIES = 3,
    parameter int PTR_W  = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce_n,
    input logic             we_n,
    input logic             re_n,
    input logic             io_oe,
    input logic             rb_n,
    input nidr_mode_e       mode,
    input logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LIMIT = PTR_W'(COPIES * PAGE_BYTES);

    logic we_q;
    logic re_q;
    logic we_up;
    logic re_dn;
    logic dmode;

    // Own copy of strobe history for edge-relative properties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            re_q <= 1'b1;
        end else begin
            we_q <= we_n;
            re_q <= re_n;
        end
    end

    assign we_up = ~we_q & we_n & ~ce_n;
    assign re_dn = re_q & ~re_n & ~ce_n;
    assign dmode = (mode == M_ID) || (mode == M_PP);

    a_r11_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_n |-> !io_oe);

    a_r4_oe_mode: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> dmode);

    a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_up |=> $stable(mode));

    a_r7_ptr_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LIMIT);

    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (re_dn && dmode && !we_up && ptr != LIMIT) |=> ptr == $past(ptr) + 1'b1);
endmodule

bind nand_id_responder nidr_chk #(.COPIES(COPIES), .PTR_W(PTR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ce_n  (ce_n),
    .we_n  (we_n),
    .re_n  (re_n),
    .io_oe (io_oe),
    .rb_n  (rb_n),
    .mode  (mode),
    .ptr   (ptr)
);

// File: tb/test_nand_id_responder.sv
module test_nand_id_responder;
    localparam int BUSY = 12;
    localparam int NRD  = 800;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       cle = 1'b0;
    logic       ale = 1'b0;
    logic       we_n = 1'b1;
    logic       re_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic       io_oe;
    logic       rb_n;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    nand_id_responder #(.BUSY_CYCLES(BUSY), .COPIES(3)) i_nand_id_responder (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .we_n(we_n), .re_n(re_n), .io_in(io_in), .io_out(io_out),
        .io_oe(io_oe), .rb_n(rb_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic is_cmd, input logic [7:0] b);
        @(negedge clk);
        ce_n = 1'b0; cle = is_cmd; ale = ~is_cmd; io_in = b; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic rd(output logic [7:0] b, output logic oe);
        @(negedge clk);
        re_n = 1'b0;
        @(negedge clk);
        b = io_out; oe = io_oe;
        re_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 7; b >= 0; b--) begin
            logic top;
            top = r[15] ^ d[b];
            r = r << 1;
            if (top) r = r ^ 16'h8005;
        end
        return r;
    endfunction

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic        oe;
        logic [7:0]  pg [NRD];
        logic [15:0] crc;
        int          n;
        logic [7:0]  idv [5];
        idv = '{8'h01, 8'hA5, 8'hD2, 8'h15, 8'h5E};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: busy while computing, output off
        chk("R1 oe after reset", io_oe, 0);
        n = 0;
        while (!rb_n && n < 1000) begin
            if (io_oe) chk("R1 oe during busy", io_oe, 0);
            n++;
            @(negedge clk);
        end
        chk("R1 power-up busy length", n, 254);

        // R2, R3, R4: ID sequence with interruptions
        wr(1, 8'h90); wr(0, 8'h00);
        for (int i = 0; i < 2; i++) begin
            rd(b, oe);
            chk("R2 id byte", b, idv[i]);
            chk("R4 oe on read", oe, 1);
        end
        ce_n = 1'b1;
        rd(b, oe);
        chk("R4 oe with ce high", oe, 0);
        ce_n = 1'b0;
        rd(b, oe);
        chk("R4 pointer held across ce high", b, idv[2]);
        wr(0, 8'h00);
        rd(b, oe);
        chk("R3 stray address ignored", b, idv[3]);
        rd(b, oe);
        chk("R2 id byte 5", b, idv[4]);
        for (int i = 0; i < 3; i++) begin
            rd(b, oe);
            chk("R2 past end", b, 8'h00);
            chk("R3 still in mode", oe, 1);
        end

        // R5, R6, R7: parameter page sweep
        wr(1, 8'hEC); wr(0, 8'h00);
        for (int i = 0; i < NRD; i++) begin
            rd(b, oe);
            pg[i] = b;
            if (!oe) chk("R5 oe in page mode", oe, 1);
        end
        chk("R5 sig0", pg[0], 8'h4F);
        chk("R5 sig1", pg[1], 8'h4E);
        chk("R5 sig2", pg[2], 8'h46);
        chk("R5 sig3", pg[3], 8'h49);
        crc = 16'h4F4E;
        for (int i = 0; i < 254; i++) crc = crc_byte(crc, pg[i]);
        chk("R6 crc low", pg[254], crc[7:0]);
        chk("R6 crc high", pg[255], crc[15:8]);
        for (int i = 256; i < 768; i++)
            if (pg[i] !== pg[i % 256]) chk("R7 copy", pg[i], pg[i % 256]);
        chk("R7 copy 2 last", pg[511], pg[255]);
        chk("R7 copy 3 first", pg[512], pg[0]);
        for (int i = 768; i < NRD; i++)
            if (pg[i] !== 8'hFF) chk("R7 fill", pg[i], 8'hFF);
        chk("R7 fill first", pg[768], 8'hFF);

        // R8: bad address after ID command
        wr(1, 8'h90); wr(0, 8'h01);
        rd(b, oe);
        chk("R8 bad id address idle", oe, 0);
        wr(1, 8'hEC); wr(0, 8'h10);
        rd(b, oe);
        chk("R8 bad page address idle", oe, 0);

        // R9: unknown command idles
        wr(1, 8'h90); wr(0, 8'h00);
        wr(1, 8'h30);
        rd(b, oe);
        chk("R9 unknown cmd oe", oe, 0);
        chk("R9 rb_n stays high", rb_n, 1);

        // R10: reset busy length
        wr(1, 8'hEC); wr(0, 8'h00);
        wr(1, 8'hFF);
        n = 0;
        while (!rb_n && n < 100) begin n++; @(negedge clk); end
        chk("R10 reset busy length", n, BUSY);
        rd(b, oe);
        chk("R10 idle after reset", oe, 0);

        // R11: commands during busy ignored
        wr(1, 8'hFF);
        chk("R11 busy asserted", rb_n, 0);
        wr(1, 8'h90); wr(0, 8'h00);
        chk("R11 still busy", rb_n, 0);
        while (!rb_n) @(negedge clk);
        rd(b, oe);
        chk("R11 id ignored while busy", oe, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule